// File: doc/BRIEF.md
# Paired-Register Double Operand Port Sharer

This block wraps a 32-entry, 32-bit integer register file so that a 32-bit core can keep double-precision floating-point values in its integer registers. A double lives in an aligned pair: an even register carries bits 31:0 and the following odd register carries bits 63:32. No ports are added. The file keeps its two read ports and one write port, and ordinary integer accesses and 64-bit pair accesses take turns on them.

A request is presented with `req_valid` and an operation code. When an operation needs two cycles, `busy` goes high in the first cycle. The upstream stage must then hold the same request for one more cycle, and the operation retires at the end of that second cycle. The block checks pair register numbers and flags odd ones as illegal. It builds 64-bit operands from the two read ports and splits 64-bit results into two writes, low word first. Pair base 0 is special: it reads as a 64-bit zero, and writes to it are dropped without touching register 1. Integer accesses to register 0 read zero and are never written.

Operation codes on `req_op`: 0 idle, 1 integer access, 2 one pair read, 3 two pair reads, 4 pair write, 5 pair move. Codes 6 and 7 behave as idle.

Top module: `dpair_regfile`

## Requirements
- R1: With op 1, `int_rdata1` and `int_rdata2` show the stored contents of `rs1` and `rs2` in the same cycle, and register 0 always reads zero.
- R2: With op 1 and `int_we` high, `int_wdata` is stored into `rd` at the end of that cycle with `busy` low. A read of the same register in that cycle returns the old value. A write to register 0 has no effect.
- R3: With op 2 and an even `rs1`, `pair_a` equals {reg[rs1+1], reg[rs1]} in the same cycle, `pair_valid` is high and `busy` is low.
- R4: A pair read with base 0 returns a 64-bit zero even when register 1 holds a nonzero value.
- R5: With op 3, `busy` is high and `pair_valid` low in the first cycle. In the second cycle `busy` is low, `pair_valid` is high, `pair_a` holds the `rs1` pair and `pair_b` holds the `rs2` pair. `busy` is never high in two consecutive cycles.
- R6: With op 4, `pair_wdata[31:0]` is written to `rd` at the end of the first cycle, with `busy` high. `pair_wdata[63:32]` is written to `rd+1` at the end of the second cycle, with `busy` low.
- R7: A pair write or pair move with destination base 0 changes no register, and register 1 keeps its value.
- R8: With op 5, the `rs1` pair is copied to the `rd` pair over two cycles (`busy` high in the first). This holds when source and destination are the same pair.
- R9: For op 2 (`rs1`), op 3 (`rs1`, `rs2`), op 4 (`rd`) and op 5 (`rs1`, `rd`), an odd number in any pair field raises `illegal` in the same cycle. `busy` and `pair_valid` then stay low and no register is written.
- R10: After a synchronous active-low reset every register reads zero and `busy` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 3 | Operation code (0..5) |
| rs1 | input | 5 | First source register or pair base |
| rs2 | input | 5 | Second source register or pair base |
| rd | input | 5 | Destination register or pair base |
| int_we | input | 1 | Write enable for an integer access |
| int_wdata | input | 32 | Integer write data |
| pair_wdata | input | 64 | Double value for a pair write |
| busy | output | 1 | Hold the current request one more cycle |
| illegal | output | 1 | Odd pair number in a pair field |
| int_rdata1 | output | 32 | Read port 0 data |
| int_rdata2 | output | 32 | Read port 1 data |
| pair_valid | output | 1 | `pair_a`/`pair_b` carry the requested operands |
| pair_a | output | 64 | First double operand |
| pair_b | output | 64 | Second double operand (op 3) |

## Verification
Two functions can fall in the same cycle. In a move (or an integer access), the source read and the destination write share one cycle. In a two-operand read, the second pair read shares a cycle with the replay of a previously captured operand. The bench provokes the first case with moves whose source and destination pairs are identical, and with integer accesses that read and write the same register. It judges them against a bench-side register model: the read must return the pre-write value, and the final contents must equal the original source. For the second case, the bench sweeps every combination of even bases, including equal ones and base 0, and compares both operands with pairs assembled from the model.

// File: rtl/dpair_pkg.sv
// Package: shared operation codes and helpers for the paired-register file.
// Assumes a 3-bit operation field; unknown codes are treated as idle.
package dpair_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_INT  = 3'd1,
        OP_PRD1 = 3'd2,
        OP_PRD2 = 3'd3,
        OP_PWR  = 3'd4,
        OP_PMOV = 3'd5
    } dp_op_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } dp_phase_e;

    // True for operations that occupy the ports for two cycles.
    function automatic logic op_two_cycle(input dp_op_e op);
        return (op == OP_PRD2) || (op == OP_PWR) || (op == OP_PMOV);
    endfunction

    // True for operations that write a destination pair.
    function automatic logic op_pair_write(input dp_op_e op);
        return (op == OP_PWR) || (op == OP_PMOV);
    endfunction

endpackage

// File: rtl/dpair_storage.sv
// Module: flop-based register array with two asynchronous read ports and
// one synchronous write port. Entry 0 is never written and reads as zero.
// Assumes the caller resolves all port sharing before this level.
module dpair_storage #(
    parameter int NREG = 32,
    parameter int XW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra0,
    input  logic [AW-1:0] ra1,
    output logic [XW-1:0] rd0,
    output logic [XW-1:0] rd1,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [XW-1:0] wd
);

    logic [XW-1:0] mem [NREG];

    // Clear on reset, otherwise commit one word per cycle (never entry 0).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            mem[wa] <= wd;
        end
    end

    // Read ports: entry 0 is forced to zero regardless of array content.
    always_comb begin
        rd0 = (ra0 == '0) ? '0 : mem[ra0];
        rd1 = (ra1 == '0) ? '0 : mem[ra1];
    end

endmodule

// File: rtl/dpair_decode.sv
// Module: checks pair register numbers for the presented request.
// A pair field with an odd number is reserved; the request is flagged in
// the cycle it first appears and is never flagged in the replay cycle.
module dpair_decode
    import dpair_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] rs1,
    input  logic [AW-1:0] rs2,
    input  logic [AW-1:0] rd,
    input  logic          in_second,
    output logic          illegal
);

    dp_op_e op;
    logic   odd_field;

    // Select which pair fields the operation uses and test their low bit.
    always_comb begin
        op = dp_op_e'(req_op);
        case (op)
            OP_PRD1: odd_field = rs1[0];
            OP_PRD2: odd_field = rs1[0] | rs2[0];
            OP_PWR:  odd_field = rd[0];
            OP_PMOV: odd_field = rs1[0] | rd[0];
            default: odd_field = 1'b0;
        endcase
        illegal = req_valid && !in_second && odd_field;
    end

endmodule

// File: rtl/dpair_seq.sv
// Module: sequencer that shares two read ports and one write port between
// integer and pair accesses. Two-cycle operations raise busy in their first
// cycle and capture what the second cycle needs, so the replay cycle does
// not depend on the held request. Assumes upstream holds a request while
// busy is high.
module dpair_seq
    import dpair_pkg::*;
#(
    parameter int AW = 5,
    parameter int XW = 32,
    localparam int PW = 2 * XW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] rs1,
    input  logic [AW-1:0] rs2,
    input  logic [AW-1:0] rd,
    input  logic          int_we,
    input  logic [XW-1:0] int_wdata,
    input  logic [PW-1:0] pair_wdata,
    input  logic          illegal,
    input  logic [XW-1:0] port_d0,
    input  logic [XW-1:0] port_d1,
    output logic [AW-1:0] port_a0,
    output logic [AW-1:0] port_a1,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [XW-1:0] wr_data,
    output logic          busy,
    output logic          in_second,
    output logic          pair_valid,
    output logic [PW-1:0] pair_a,
    output logic [PW-1:0] pair_b
);

    dp_phase_e     phase;
    dp_op_e        op;
    dp_op_e        sec_op;
    logic [AW-1:0] sec_rd;
    logic [AW-1:0] sec_rs2;
    logic [PW-1:0] hold;
    logic          first_go;
    logic [AW-1:0] rs1_even;
    logic [AW-1:0] rs2_even;
    logic [PW-1:0] pair_now;

    // Request qualification and busy generation for the first cycle.
    always_comb begin
        op        = dp_op_e'(req_op);
        in_second = (phase == PH_SECOND);
        first_go  = req_valid && !in_second && !illegal;
        busy      = first_go && op_two_cycle(op);
        rs1_even  = {rs1[AW-1:1], 1'b0};
        rs2_even  = {rs2[AW-1:1], 1'b0};
    end

    // Read-port address steering: replay reads the captured second pair.
    always_comb begin
        if (in_second) begin
            port_a0 = sec_rs2;
            port_a1 = {sec_rs2[AW-1:1], 1'b1};
        end else if (op == OP_INT) begin
            port_a0 = rs1;
            port_a1 = rs2;
        end else begin
            port_a0 = rs1_even;
            port_a1 = {rs1[AW-1:1], 1'b1};
        end
    end

    // Operand assembly: pair base 0 yields a full 64-bit zero.
    always_comb begin
        pair_now   = (port_a0 == '0) ? '0 : {port_d1, port_d0};
        pair_a     = in_second ? hold : pair_now;
        pair_b     = in_second ? pair_now : '0;
        pair_valid = (first_go && (op == OP_PRD1))
                   || (in_second && (sec_op == OP_PRD2));
    end

    // Write-port steering: low word in the first cycle, high word in replay.
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        if (in_second) begin
            if (op_pair_write(sec_op) && (sec_rd != '0)) begin
                wr_en   = 1'b1;
                wr_addr = {sec_rd[AW-1:1], 1'b1};
                wr_data = hold[PW-1:XW];
            end
        end else if (first_go) begin
            case (op)
                OP_INT: begin
                    wr_en   = int_we && (rd != '0);
                    wr_addr = rd;
                    wr_data = int_wdata;
                end
                OP_PWR: begin
                    wr_en   = (rd != '0);
                    wr_addr = rd;
                    wr_data = pair_wdata[XW-1:0];
                end
                OP_PMOV: begin
                    wr_en   = (rd != '0);
                    wr_addr = rd;
                    wr_data = pair_now[XW-1:0];
                end
                default: begin
                    wr_en = 1'b0;
                end
            endcase
        end
    end

    // Phase register and capture of everything the replay cycle needs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_FIRST;
            sec_op  <= OP_NONE;
            sec_rd  <= '0;
            sec_rs2 <= '0;
            hold    <= '0;
        end else if (in_second) begin
            phase <= PH_FIRST;
        end else if (busy) begin
            phase   <= PH_SECOND;
            sec_op  <= op;
            sec_rd  <= rd;
            sec_rs2 <= rs2_even;
            hold    <= (op == OP_PWR) ? pair_wdata : pair_now;
        end
    end

endmodule

// File: rtl/dpair_regfile.sv
// Module: top of the paired-register file. Joins the number check, the
// port-sharing sequencer and the storage array. Assumes a single request
// stream that is held while busy is high.
module dpair_regfile #(
    parameter int NREG = 32,
    parameter int XW   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [2:0]            req_op,
    input  logic [$clog2(NREG)-1:0] rs1,
    input  logic [$clog2(NREG)-1:0] rs2,
    input  logic [$clog2(NREG)-1:0] rd,
    input  logic                  int_we,
    input  logic [XW-1:0]         int_wdata,
    input  logic [2*XW-1:0]       pair_wdata,
    output logic                  busy,
    output logic                  illegal,
    output logic [XW-1:0]         int_rdata1,
    output logic [XW-1:0]         int_rdata2,
    output logic                  pair_valid,
    output logic [2*XW-1:0]       pair_a,
    output logic [2*XW-1:0]       pair_b
);

    localparam int AW = $clog2(NREG);

    logic [AW-1:0] port_a0;
    logic [AW-1:0] port_a1;
    logic [XW-1:0] port_d0;
    logic [XW-1:0] port_d1;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [XW-1:0] wr_data;
    logic          in_second;

    dpair_decode #(.AW(AW)) u_decode (
        .req_valid (req_valid),
        .req_op    (req_op),
        .rs1       (rs1),
        .rs2       (rs2),
        .rd        (rd),
        .in_second (in_second),
        .illegal   (illegal)
    );

    dpair_seq #(.AW(AW), .XW(XW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .rs1        (rs1),
        .rs2        (rs2),
        .rd         (rd),
        .int_we     (int_we),
        .int_wdata  (int_wdata),
        .pair_wdata (pair_wdata),
        .illegal    (illegal),
        .port_d0    (port_d0),
        .port_d1    (port_d1),
        .port_a0    (port_a0),
        .port_a1    (port_a1),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .busy       (busy),
        .in_second  (in_second),
        .pair_valid (pair_valid),
        .pair_a     (pair_a),
        .pair_b     (pair_b)
    );

    dpair_storage #(.NREG(NREG), .XW(XW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .ra0   (port_a0),
        .ra1   (port_a1),
        .rd0   (port_d0),
        .rd1   (port_d1),
        .we    (wr_en),
        .wa    (wr_addr),
        .wd    (wr_data)
    );

    // Integer read data is the raw port data.
    always_comb begin
        int_rdata1 = port_d0;
        int_rdata2 = port_d1;
    end

endmodule

// File: rtl/dpair_checker.sv
// Module: temporal checks on the paired-register file, attached by bind.
// Assumes request fields are meaningful only while req_valid is high.
module dpair_checker #(
    parameter int AW = 5,
    parameter int XW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [2:0]    req_op,
    input logic [AW-1:0] rs1,
    input logic          busy,
    input logic          illegal,
    input logic          pair_valid,
    input logic [XW-1:0] int_rdata1,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          in_second
);

    // Register 0 reads zero on an integer access.
    assert_x0_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd1 && rs1 == '0 && !in_second) |-> (int_rdata1 == '0));

    // Integer accesses never stall.
    assert_int_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd1 && !in_second) |-> !busy);

    // A stall lasts exactly one cycle.
    assert_busy_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // The replay cycle follows a stalled cycle.
    assert_replay_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_second |-> $past(busy));

    // Entry 0 is never addressed by a committed write.
    assert_no_x0_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr != '0));

    // An illegal request writes nothing and neither stalls nor delivers.
    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && !busy && !pair_valid));

endmodule

bind dpair_regfile dpair_checker #(.AW(AW), .XW(XW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .rs1        (rs1),
    .busy       (busy),
    .illegal    (illegal),
    .pair_valid (pair_valid),
    .int_rdata1 (int_rdata1),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .in_second  (in_second)
);

// File: tb/dpair_regfile_tb.sv
// Bench: sweeps every register, pair base and odd number against a
// bench-side register model.
module dpair_regfile_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [4:0]  rs1 = '0, rs2 = '0, rd = '0;
    logic        int_we = 1'b0;
    logic [31:0] int_wdata = '0;
    logic [63:0] pair_wdata = '0;
    logic        busy, illegal, pair_valid;
    logic [31:0] int_rdata1, int_rdata2;
    logic [63:0] pair_a, pair_b;

    logic [31:0] model [32];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dpair_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .rs1(rs1), .rs2(rs2), .rd(rd), .int_we(int_we), .int_wdata(int_wdata),
        .pair_wdata(pair_wdata), .busy(busy), .illegal(illegal),
        .int_rdata1(int_rdata1), .int_rdata2(int_rdata2),
        .pair_valid(pair_valid), .pair_a(pair_a), .pair_b(pair_b)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkval(input int i, input int salt);
        return (32'(i) * 32'h9E3779B1) ^ (32'(salt) * 32'h01000193);
    endfunction

    function automatic logic [63:0] mpair(input int b);
        return (b == 0) ? 64'd0 : {model[b + 1], model[b]};
    endfunction

    task automatic drive(input bit v, input int op, input int a, input int b, input int d,
                         input bit we, input logic [31:0] iw, input logic [63:0] pw);
        @(negedge clk);
        req_valid = v; req_op = 3'(op); rs1 = 5'(a); rs2 = 5'(b); rd = 5'(d);
        int_we = we; int_wdata = iw; pair_wdata = pw;
        #1;
    endtask

    task automatic do_int(input int a, input int b, input int d, input bit we, input logic [31:0] w);
        drive(1, 1, a, b, d, we, w, 64'd0);
        check(int_rdata1 == model[a], "R1 int port0", {32'd0, int_rdata1}, {32'd0, model[a]});
        check(int_rdata2 == model[b], "R1 int port1", {32'd0, int_rdata2}, {32'd0, model[b]});
        check(!busy && !illegal, "R2 int no busy", {62'd0, busy, illegal}, 64'd0);
        if (we && d != 0) model[d] = w;
    endtask

    task automatic dump_all(input string tag);
        for (int i = 0; i < 32; i++) begin
            drive(1, 1, i, 31 - i, 0, 0, '0, '0);
            check(int_rdata1 == model[i] && int_rdata2 == model[31 - i], tag,
                  {int_rdata1, int_rdata2}, {model[i], model[31 - i]});
        end
    endtask

    task automatic do_rd1(input int b);
        drive(1, 2, b, 0, 0, 0, '0, '0);
        check(pair_valid && !busy && pair_a == mpair(b), (b == 0) ? "R4 pair base0 zero" : "R3 pair read",
              pair_a, mpair(b));
    endtask

    task automatic do_rd2(input int a, input int b);
        drive(1, 3, a, b, 0, 0, '0, '0);
        check(busy && !pair_valid, "R5 first cycle busy", {62'd0, busy, pair_valid}, 64'd2);
        @(negedge clk); #1;
        check(!busy && pair_valid, "R5 second cycle valid", {62'd0, busy, pair_valid}, 64'd1);
        check(pair_a == mpair(a), "R5 operand a", pair_a, mpair(a));
        check(pair_b == mpair(b), "R5 operand b", pair_b, mpair(b));
    endtask

    task automatic do_wr(input int d, input logic [63:0] v);
        drive(1, 4, 0, 0, d, 0, '0, v);
        check(busy, "R6 write first busy", {63'd0, busy}, 64'd1);
        @(negedge clk); #1;
        check(!busy, "R6 write second idle", {63'd0, busy}, 64'd0);
        if (d != 0) begin model[d] = v[31:0]; model[d + 1] = v[63:32]; end
    endtask

    task automatic do_mv(input int s, input int d);
        logic [63:0] v;
        v = mpair(s);
        drive(1, 5, s, 0, d, 0, '0, '0);
        check(busy, "R8 move first busy", {63'd0, busy}, 64'd1);
        @(negedge clk); #1;
        check(!busy, "R8 move second idle", {63'd0, busy}, 64'd0);
        if (d != 0) begin model[d] = v[31:0]; model[d + 1] = v[63:32]; end
    endtask

    task automatic do_bad(input int op, input int a, input int b, input int d);
        drive(1, op, a, b, d, 1, 32'hDEAD_0000, 64'hBAD0_BAD0_BAD0_BAD0);
        check(illegal && !busy && !pair_valid, "R9 odd pair flagged",
              {61'd0, illegal, busy, pair_valid}, 64'd4);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check(!busy && !illegal, "R10 reset outputs", {62'd0, busy, illegal}, 64'd0);
        dump_all("R10 reset contents");

        // R2: write every register while reading the same one (old value seen).
        for (int i = 0; i < 32; i++) do_int(i, (i + 1) % 32, i, 1, mkval(i, 1));
        dump_all("R1 integer contents");
        do_int(0, 0, 0, 1, 32'hFFFF_FFFF);
        dump_all("R2 x0 write ignored");

        // R3 / R4: every pair base, single operand.
        for (int b = 0; b < 32; b += 2) do_rd1(b);

        // R5: every combination of two bases.
        for (int a = 0; a < 32; a += 2)
            for (int b = 0; b < 32; b += 2) do_rd2(a, b);

        // R6 / R7: pair writes to every base, base 0 must not touch register 1.
        for (int b = 0; b < 32; b += 2)
            do_wr(b, {mkval(b, 7), mkval(b, 3)});
        dump_all("R6 pair write contents");
        check(model[1] == mkval(1, 1), "R7 register 1 kept", {32'd0, model[1]}, {32'd0, mkval(1, 1)});
        for (int b = 0; b < 32; b += 2) do_rd1(b);

        // R8 / R7: moves, including same pair, from base 0 and to base 0.
        do_mv(4, 4);
        do_mv(6, 10);
        do_mv(30, 2);
        do_mv(0, 12);
        do_mv(14, 0);
        for (int b = 16; b < 30; b += 2) do_mv(b + 2, b);
        dump_all("R8 move contents");
        drive(1, 1, 1, 0, 0, 0, '0, '0);
        check(int_rdata1 == mkval(1, 1), "R7 register 1 after moves", {32'd0, int_rdata1}, {32'd0, mkval(1, 1)});

        // R9: every odd number in every pair field.
        for (int r = 1; r < 32; r += 2) begin
            do_bad(2, r, 0, 0);
            do_bad(3, r, 4, 0);
            do_bad(3, 4, r, 0);
            do_bad(4, 0, 0, r);
            do_bad(5, r, 0, 2);
            do_bad(5, 2, 0, r);
        end
        dump_all("R9 no write after illegal");

        drive(0, 0, 0, 0, 0, 0, '0, '0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule